// File: doc/BRIEF.md
# Message Fragmenting Transmitter

This block sends one byte message to a peer through an outbound slot buffer whose slots are 32 bits wide. A request carries a byte count, an 8-bit host address and an 8-bit client address. The block cuts the message into fragments. Each fragment is written as a header slot followed by body slots that hold 4 bytes each. After each fragment it pulses a doorbell so the peer knows new slots are waiting.

The largest fragment follows from two limits: the byte capacity of the buffer (its depth in slots times 4) and the 9-bit length field of the header, with one slot kept back for the header. Before it writes, the block waits until the buffer reports enough empty slots. Message bytes arrive on a valid/ready byte stream, and the block accepts bytes only while it is writing a body. When the request ends, a one-cycle done pulse reports success or failure. A request of zero bytes fails and sends nothing. If the peer is no longer ready when a fragment has been written, the request fails.

Top module: `msg_frag_tx`

## Requirements
- R1: A header slot is {complete, 6'b0, length[8:0], host[7:0], client[7:0]}. The complete flag is bit 31, the byte length is in bits 24:16, the host address is in bits 15:8 and the client address is in bits 7:0.
- R2: A fragment length is min(remaining, min(4*depth, 511) - 4). Depth must be at least 2.
- R3: The complete flag is 1 only on the header of the fragment that carries the last remaining bytes. It is 0 on every earlier fragment.
- R4: A header slot is written only in a cycle after empty_slots was sampled nonzero.
- R5: Body slots of a fragment are written only after empty_slots was sampled at or above ceil(length/4).
- R6: Body bytes are packed little-endian, with the first byte in bits 7:0. In the last slot of a fragment, the bytes past the fragment length are 0.
- R7: A start with msg_len of 0 gives done=1 and ok=0 in the next cycle, with no slot write and no doorbell.
- R8: Exactly one doorbell pulse follows each fragment. It comes in the cycle after the fragment's last body slot write.
- R9: If peer_ready is low in the cycle after the last body slot of a fragment, the request ends with done=1 and ok=0, and no further fragment is written.
- R10: When the final fragment succeeds, done=1 and ok=1 come in the same cycle as its doorbell.
- R11: A start pulse while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| msg_len | input | LEN_W | Message length in bytes |
| host_addr | input | 8 | Host address for the headers |
| client_addr | input | 8 | Client address for the headers |
| buf_depth | input | DEPTH_W | Buffer capacity in slots |
| empty_slots | input | DEPTH_W | Current count of empty buffer slots |
| peer_ready | input | 1 | Peer ready flag |
| byte_valid | input | 1 | Message byte is present |
| byte_data | input | 8 | Message byte |
| byte_ready | output | 1 | Block takes a byte this cycle if valid |
| slot_wr | output | 1 | Slot write strobe |
| slot_data | output | 32 | Slot word |
| doorbell | output | 1 | Interrupt-generate pulse after a fragment |
| done | output | 1 | End-of-request pulse |
| ok | output | 1 | Request succeeded, valid with done |

## Verification
Two events can fall in the same cycle: the doorbell of the final fragment and the done pulse that closes the request. The bench reaches this case with every successful request. It also reaches it with a request whose peer drops ready after the first fragment. For both, the monitor records whether doorbell was high in the cycle where done was seen and compares this with the expected fragment count. The monitor also checks that the cycle before each doorbell carried a slot write. Random byte stalls and small buffer depths give many fragment boundaries under varied timing.

// File: rtl/msg_frag_tx.sv
module msg_frag_tx #(
  parameter int LEN_W   = 12,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   msg_len,
  input  logic [7:0]         host_addr,
  input  logic [7:0]         client_addr,
  input  logic [DEPTH_W-1:0] buf_depth,
  input  logic [DEPTH_W-1:0] empty_slots,
  input  logic               peer_ready,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  output logic               byte_ready,
  output logic               slot_wr,
  output logic [31:0]        slot_data,
  output logic               doorbell,
  output logic               done,
  output logic               ok
);
  localparam int CAPW = DEPTH_W + 2;
  localparam int CMPW = (DEPTH_W > 9) ? DEPTH_W : 9;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_BWAIT, S_BODY, S_RING} st_t;
  st_t st;

  logic [LEN_W-1:0]   rem_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [7:0]         host_q, client_q;
  logic [8:0]         flen_q, left_q;
  logic [1:0]         bidx;
  logic [31:0]        word;

  logic [CAPW-1:0] cap_b;
  logic [8:0]      lim, max_len, frag_len, need;
  logic            last_frag, fire;
  logic [31:0]     nword;

  assign cap_b     = {depth_q, 2'b00};
  assign lim       = (cap_b > CAPW'(511)) ? 9'd511 : 9'(cap_b);
  assign max_len   = lim - 9'd4;
  assign frag_len  = (rem_q > LEN_W'(max_len)) ? max_len : 9'(rem_q);
  assign last_frag = (LEN_W'(frag_len) == rem_q);
  assign need      = (flen_q + 9'd3) >> 2;
  assign byte_ready = (st == S_BODY);
  assign fire      = byte_valid && byte_ready;
  assign nword     = word | ({24'b0, byte_data} << {bidx, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem_q <= '0; depth_q <= '0; host_q <= '0; client_q <= '0;
      flen_q <= '0; left_q <= '0; bidx <= '0; word <= '0;
      slot_wr <= 1'b0; slot_data <= '0; doorbell <= 1'b0; done <= 1'b0; ok <= 1'b0;
    end else begin
      slot_wr  <= 1'b0;
      doorbell <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (msg_len == '0) begin
            done <= 1'b1;
          end else begin
            rem_q <= msg_len; depth_q <= buf_depth;
            host_q <= host_addr; client_q <= client_addr;
            st <= S_HDR;
          end
        end
        S_HDR: if (empty_slots != '0) begin
          slot_wr   <= 1'b1;
          slot_data <= {last_frag, 6'b0, frag_len, host_q, client_q};
          flen_q    <= frag_len;
          left_q    <= frag_len;
          rem_q     <= rem_q - LEN_W'(frag_len);
          word      <= '0;
          bidx      <= '0;
          st        <= S_BWAIT;
        end
        S_BWAIT: if (CMPW'(empty_slots) >= CMPW'(need)) st <= S_BODY;
        S_BODY: if (fire) begin
          left_q <= left_q - 9'd1;
          if (bidx == 2'd3 || left_q == 9'd1) begin
            slot_wr   <= 1'b1;
            slot_data <= nword;
            word      <= '0;
            bidx      <= '0;
          end else begin
            word <= nword;
            bidx <= bidx + 2'd1;
          end
          if (left_q == 9'd1) st <= S_RING;
        end
        S_RING: begin
          doorbell <= 1'b1;
          if (!peer_ready || rem_q == '0) begin
            done <= 1'b1;
            ok   <= peer_ready;
            st   <= S_IDLE;
          end else begin
            st <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BWAIT && $past(st) == S_HDR) |->
      (slot_data[24:16] <= max_len && slot_data[24:16] != 9'd0));
  p_hdr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && empty_slots == '0) |=> !slot_wr);
  p_body_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BWAIT) |=> !slot_wr);
  p_zero_rej_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && msg_len == '0) |=> (done && !ok && !slot_wr));
  p_bell_after_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(slot_wr));
  p_ok_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BODY && start) |=> (st != S_HDR));
endmodule

// File: tb/msg_frag_tx_tb.sv
module msg_frag_tx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0; logic [11:0] msg_len = 0;
  logic [7:0] host_addr = 0, client_addr = 0;
  logic [7:0] buf_depth = 8, empty_slots = 0;
  logic peer_ready = 1, byte_valid = 0; logic [7:0] byte_data = 0;
  logic byte_ready, slot_wr, doorbell, done, ok; logic [31:0] slot_data;

  always #2.5 clk = ~clk;

  msg_frag_tx #(.LEN_W(12), .DEPTH_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .host_addr(host_addr), .client_addr(client_addr), .buf_depth(buf_depth),
    .empty_slots(empty_slots), .peer_ready(peer_ready), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .slot_wr(slot_wr),
    .slot_data(slot_data), .doorbell(doorbell), .done(done), .ok(ok));

  int n_chk = 0, n_err = 0;
  logic [7:0]  msg [0:1023];
  logic [31:0] cap [0:1023];
  logic [31:0] expv[0:1023];
  int cap_n, db_n, db_bad, ne, nf, cur_len, ptr;
  bit pend, done_seen, done_ok, done_db, prev_wr;

  task automatic chk(bit c, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!c) begin n_err++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (pend) ptr++;
    byte_valid = (ptr < cur_len) && ($urandom % 4 != 0);
    byte_data  = msg[ptr % 1024];
    pend = byte_valid && byte_ready;
  end

  always @(negedge clk) begin
    if (slot_wr) begin if (cap_n < 1024) cap[cap_n] = slot_data; cap_n++; end
    if (doorbell) begin db_n++; if (!prev_wr) db_bad++; end
    if (done) begin done_seen = 1; done_ok = ok; done_db = doorbell; end
    prev_wr = slot_wr;
  end

  task automatic build_exp(int len, int depth, bit first_only);
    int rem, pos, maxl, fl, w;
    rem = len; pos = 0; ne = 0; nf = 0;
    maxl = ((depth * 4 < 511) ? depth * 4 : 511) - 4;
    while (rem > 0) begin
      fl = (rem < maxl) ? rem : maxl;
      expv[ne++] = {(fl == rem), 6'b0, 9'(fl), host_addr, client_addr};
      for (int i = 0; i < (fl + 3) / 4; i++) begin
        w = 0;
        for (int b = 0; b < 4; b++)
          if (i * 4 + b < fl) w = w | (int'(msg[pos + i * 4 + b]) << (8 * b));
        expv[ne++] = w;
      end
      pos += fl; rem -= fl; nf++;
      if (first_only) break;
    end
  endtask

  task automatic begin_msg(int len, int depth, bit pr, bit first_only);
    step();
    for (int i = 0; i < 1024; i++) msg[i] = 8'($urandom);
    host_addr = 8'($urandom); client_addr = 8'($urandom);
    buf_depth = 8'(depth); peer_ready = pr;
    cap_n = 0; db_n = 0; db_bad = 0; done_seen = 0; done_ok = 0; done_db = 0;
    ptr = 0; pend = 0; cur_len = len;
    build_exp(len, depth, first_only);
    msg_len = 12'(len); start = 1;
    step();
    start = 0;
  endtask

  task automatic end_msg(bit exp_ok, string tag);
    int t = 0;
    while (!done_seen && t < 20000) begin step(); t++; end
    step(3);
    chk(done_seen, {tag, " R10 done seen"}, 32'(done_seen), 1);
    chk(done_ok == exp_ok, {tag, " R9 R10 ok flag"}, 32'(done_ok), 32'(exp_ok));
    chk(cap_n == ne, {tag, " R2 slot count"}, cap_n, ne);
    begin
      int bad = -1;
      for (int i = 0; i < ne && i < cap_n; i++) if (cap[i] !== expv[i] && bad < 0) bad = i;
      chk(bad < 0, {tag, " R1 R3 R6 slot contents"},
          (bad < 0) ? 0 : cap[bad], (bad < 0) ? 0 : expv[bad]);
    end
    chk(db_n == nf, {tag, " R8 doorbell count"}, db_n, nf);
    chk(db_bad == 0, {tag, " R8 doorbell follows slot"}, db_bad, 0);
    chk(done_db == (nf != 0), {tag, " R10 done with doorbell"}, 32'(done_db), 32'(nf != 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    cur_len = 0; ptr = 0; pend = 0; cap_n = 0; db_n = 0; db_bad = 0;
    step(3);
    rst_n = 1;
    step();
    chk(!slot_wr && !doorbell && !done && !byte_ready, "reset outputs idle",
        {slot_wr, doorbell, done, byte_ready}, 0);
    empty_slots = 8'd255;

    begin_msg(0, 8, 1, 0);
    end_msg(0, "R7 zero length");

    begin_msg(1, 8, 1, 0);
    end_msg(1, "R6 one byte pad");

    begin_msg(28, 8, 1, 0);
    end_msg(1, "R3 exact max single");

    begin_msg(29, 8, 1, 0);
    end_msg(1, "R3 max plus one");

    begin_msg(600, 255, 1, 0);
    end_msg(1, "R2 depth 255");
    chk(cap[0][24:16] == 9'd507, "R2 header length cap 507", cap[0][24:16], 507);

    begin_msg(100, 8, 0, 1);
    end_msg(0, "R9 peer not ready");

    empty_slots = 0;
    begin_msg(10, 4, 1, 0);
    step(10);
    chk(cap_n == 0, "R4 no header without space", cap_n, 0);
    empty_slots = 1;
    step(5);
    chk(cap_n == 1, "R4 header after one slot", cap_n, 1);
    empty_slots = 2;
    msg_len = 12'd7; start = 1;
    step();
    start = 0;
    step(5);
    chk(cap_n == 1, "R5 body held below need", cap_n, 1);
    empty_slots = 3;
    end_msg(1, "R11 busy start ignored");
    empty_slots = 8'd255;

    for (int k = 0; k < 30; k++) begin
      int d, l;
      d = (k % 3 == 0) ? 2 + int'($urandom % 254) : 2 + int'($urandom % 20);
      l = 1 + int'($urandom % 600);
      begin_msg(l, d, 1, 0);
      end_msg(1, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule